// File: doc/BRIEF.md
# DDS Tuning Word Loader

This block assembles the 40-bit tuning word that drives a direct digital synthesizer. The word has two parts: a 32-bit frequency word and an 8-bit control byte. The control byte carries a 5-bit phase offset and a power-down flag. The word is built up in a staging register. Software or a host sequencer fills that register through a word-load strobe. Each strobe carries either one byte on an 8-bit data bus or one bit on the top line of that bus. A mode input chooses between the two.

Filling the staging register does not change the synthesizer. A separate update strobe copies the staged word into the committed frequency, phase and power-down outputs, and it rewinds the load pointer so the next word starts from the beginning. Both strobes are asynchronous to the system clock. They pass through synchronizers, and only their rising edges take effect. A master reset clears the committed outputs and the pointer. It leaves the staging register untouched, so a word staged before reset can still be committed after it.

Top module: `tw_loader`

## Requirements
- R1: While reset is asserted, `freq_word`, `phase_off` and `pwr_down` are zero and the load pointer returns to its start. The staging register keeps its contents, so an update after reset commits the word staged before reset.
- R2: In parallel mode (`serial_mode`=0), strobe 0 loads the control byte. Strobes 1 to 4 load the frequency word one byte at a time, most significant byte first, with data bit 7 as the byte MSB.
- R3: The control byte maps to the outputs as follows: bits 7..3 form `phase_off` (bit 7 is its MSB), bit 2 is `pwr_down`, and bits 1..0 are not brought out.
- R4: In serial mode (`serial_mode`=1), each strobe shifts in `data_in[7]` and ignores `data_in[6:0]`. The 40 bits arrive LSB first: frequency bit 0 first, frequency bit 31 on the 32nd strobe, then control bits 0 to 7.
- R5: Word-load strobes after the fifth byte (parallel mode) or after the fortieth bit (serial mode) are ignored until the next update.
- R6: The three outputs change only in response to an update strobe. Loading bytes or bits alone leaves them unchanged.
- R7: An update strobe returns the load pointer to byte or bit 0, so a partly loaded word is abandoned and the next load starts afresh.
- R8: Each strobe acts once per rising edge. A strobe that is held high for many clock cycles counts as a single byte or bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low master reset, released synchronously inside |
| serial_mode | input | 1 | 1 = serial bit loading on data bit 7, 0 = parallel byte loading |
| wld_in | input | 1 | Word-load strobe, asynchronous, acts on its rising edge |
| upd_in | input | 1 | Update strobe, asynchronous, acts on its rising edge |
| data_in | input | 8 | Byte data, or serial bit on bit 7 |
| freq_word | output | 32 | Committed frequency word |
| phase_off | output | 5 | Committed phase offset |
| pwr_down | output | 1 | Committed power-down flag |

## Verification
The checker watches several rules on every clock cycle. It confirms that the outputs move only in the cycle after a detected update edge, and that they then equal the staged word. It confirms that the pointer is rewound after every update and never passes forty. It also confirms that a serial strobe places bit 7 at the top of the shift register, and that a strobe arriving on a full parallel word leaves the staging register alone. Some behaviour can only be shown by the bench's scenarios: the byte order and field mapping seen end to end, extra strobes being dropped, an abandoned partial word, a long strobe counting once, and a staged word that survives reset. The bench checks all of these through the outputs.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam int FREQ_W    = 32;
  localparam int CTRL_W    = 8;
  localparam int BUS_W     = 8;
  localparam int PHASE_W   = 5;
  localparam int PHASE_LSB = 3;
  localparam int PD_BIT    = 2;
  localparam int SYNC_N    = 2;

  // Bit position of parallel lane k inside the staging word:
  // lane 0 is the control byte above the frequency word, lanes 1.. walk
  // down the frequency word from its most significant byte.
  function automatic int lane_lsb(input int k, input int fw, input int bw);
    if (k == 0) return fw;
    return fw - k * bw;
  endfunction

endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb chain_d = {chain_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[1];

endmodule

// File: rtl/tw_edge_sync.sv
module tw_edge_sync #(
  parameter int STAGES = tw_pkg::SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  // STAGES synchronizer flops followed by one history flop
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/tw_stage.sv
module tw_stage #(
  parameter  int FREQ_W = tw_pkg::FREQ_W,
  parameter  int CTRL_W = tw_pkg::CTRL_W,
  parameter  int BUS_W  = tw_pkg::BUS_W,
  localparam int WORD_W = FREQ_W + CTRL_W,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_mode,
  input  logic              wld_rise,
  input  logic              upd_rise,
  input  logic [BUS_W-1:0]  data,
  output logic [WORD_W-1:0] stage_q,
  output logic [CNT_W-1:0]  cnt_q
);

  localparam int NLANES = WORD_W / BUS_W;

  logic [WORD_W-1:0] stage_d;
  logic [WORD_W-1:0] par_word;
  logic [NLANES-1:0] lane_hit;
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  limit;
  logic              accept;

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    localparam int LSB = tw_pkg::lane_lsb(k, FREQ_W, BUS_W);
    assign lane_hit[k] = (cnt_q == CNT_W'(k));
    assign par_word[LSB +: BUS_W] = lane_hit[k] ? data : stage_q[LSB +: BUS_W];
  end

  assign limit  = serial_mode ? CNT_W'(WORD_W) : CNT_W'(NLANES);
  assign accept = wld_rise & ~upd_rise & (cnt_q < limit);

  always_comb begin
    stage_d = stage_q;
    cnt_d   = cnt_q;
    if (upd_rise) begin
      cnt_d = '0;
    end else if (accept) begin
      cnt_d = cnt_q + 1'b1;
      if (serial_mode) stage_d = {data[BUS_W-1], stage_q[WORD_W-1:1]};
      else             stage_d = par_word;
    end
  end

  // Staging register is deliberately outside the reset domain
  always_ff @(posedge clk) begin
    stage_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tw_commit.sv
module tw_commit #(
  parameter  int FREQ_W    = tw_pkg::FREQ_W,
  parameter  int CTRL_W    = tw_pkg::CTRL_W,
  parameter  int PHASE_W   = tw_pkg::PHASE_W,
  parameter  int PHASE_LSB = tw_pkg::PHASE_LSB,
  parameter  int PD_BIT    = tw_pkg::PD_BIT,
  localparam int WORD_W    = FREQ_W + CTRL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_rise,
  input  logic [WORD_W-1:0]  stage,
  output logic [FREQ_W-1:0]  freq_q,
  output logic [PHASE_W-1:0] phase_q,
  output logic               pd_q
);

  logic [FREQ_W-1:0]  freq_d;
  logic [PHASE_W-1:0] phase_d;
  logic               pd_d;
  logic               unused_ctrl;

  assign unused_ctrl = ^stage[FREQ_W +: PD_BIT];

  always_comb begin
    freq_d  = freq_q;
    phase_d = phase_q;
    pd_d    = pd_q;
    if (upd_rise) begin
      freq_d  = stage[FREQ_W-1:0];
      phase_d = stage[FREQ_W + PHASE_LSB +: PHASE_W];
      pd_d    = stage[FREQ_W + PD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q  <= '0;
      phase_q <= '0;
      pd_q    <= 1'b0;
    end else begin
      freq_q  <= freq_d;
      phase_q <= phase_d;
      pd_q    <= pd_d;
    end
  end

endmodule

// File: rtl/tw_loader.sv
module tw_loader #(
  parameter  int FREQ_W    = tw_pkg::FREQ_W,
  parameter  int CTRL_W    = tw_pkg::CTRL_W,
  parameter  int BUS_W     = tw_pkg::BUS_W,
  parameter  int PHASE_W   = tw_pkg::PHASE_W,
  parameter  int PHASE_LSB = tw_pkg::PHASE_LSB,
  parameter  int PD_BIT    = tw_pkg::PD_BIT,
  parameter  int SYNC_N    = tw_pkg::SYNC_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               serial_mode,
  input  logic               wld_in,
  input  logic               upd_in,
  input  logic [BUS_W-1:0]   data_in,
  output logic [FREQ_W-1:0]  freq_word,
  output logic [PHASE_W-1:0] phase_off,
  output logic               pwr_down
);

  localparam int WORD_W = FREQ_W + CTRL_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic              rst_sn;
  logic              wld_rise;
  logic              upd_rise;
  logic [WORD_W-1:0] stage_q;
  logic [CNT_W-1:0]  cnt_q;

  tw_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  tw_edge_sync #(.STAGES(SYNC_N)) u_wld_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .din   (wld_in),
    .rise  (wld_rise)
  );

  tw_edge_sync #(.STAGES(SYNC_N)) u_upd_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .din   (upd_in),
    .rise  (upd_rise)
  );

  tw_stage #(.FREQ_W(FREQ_W), .CTRL_W(CTRL_W), .BUS_W(BUS_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_sn),
    .serial_mode (serial_mode),
    .wld_rise    (wld_rise),
    .upd_rise    (upd_rise),
    .data        (data_in),
    .stage_q     (stage_q),
    .cnt_q       (cnt_q)
  );

  tw_commit #(
    .FREQ_W(FREQ_W), .CTRL_W(CTRL_W), .PHASE_W(PHASE_W),
    .PHASE_LSB(PHASE_LSB), .PD_BIT(PD_BIT)
  ) u_commit (
    .clk      (clk),
    .rst_n    (rst_sn),
    .upd_rise (upd_rise),
    .stage    (stage_q),
    .freq_q   (freq_word),
    .phase_q  (phase_off),
    .pd_q     (pwr_down)
  );

endmodule

// File: rtl/tw_loader_chk.sv
module tw_loader_chk #(
  parameter int FREQ_W    = 32,
  parameter int CTRL_W    = 8,
  parameter int BUS_W     = 8,
  parameter int PHASE_W   = 5,
  parameter int PHASE_LSB = 3,
  parameter int PD_BIT    = 2,
  parameter int WORD_W    = FREQ_W + CTRL_W,
  parameter int CNT_W     = $clog2(WORD_W + 1)
) (
  input logic               clk,
  input logic               rst_sn,
  input logic               serial_mode,
  input logic               wld_rise,
  input logic               upd_rise,
  input logic [BUS_W-1:0]   data_in,
  input logic [WORD_W-1:0]  stage_q,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [FREQ_W-1:0]  freq_word,
  input logic [PHASE_W-1:0] phase_off,
  input logic               pwr_down
);

  localparam int NLANES = WORD_W / BUS_W;

  always @(posedge clk) begin
    if (!rst_sn) begin
      // R1
      rst_clear_chk: assert (freq_word == '0 && phase_off == '0 && !pwr_down && cnt_q == '0);
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (freq_word != $past(freq_word) || phase_off != $past(phase_off) || pwr_down != $past(pwr_down))
      |-> $past(upd_rise));

  // R3
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    upd_rise |=> (freq_word == $past(stage_q[FREQ_W-1:0])
               && phase_off == $past(stage_q[FREQ_W + PHASE_LSB +: PHASE_W])
               && pwr_down  == $past(stage_q[FREQ_W + PD_BIT])));

  // R7
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    upd_rise |=> (cnt_q == '0));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= CNT_W'(WORD_W));

  // R5
  par_full_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wld_rise && !upd_rise && !serial_mode && cnt_q >= CNT_W'(NLANES))
      |=> ($stable(stage_q) && $stable(cnt_q)));

  // R4
  ser_shift_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wld_rise && !upd_rise && serial_mode && cnt_q < CNT_W'(WORD_W))
      |=> (stage_q[WORD_W-1] == $past(data_in[BUS_W-1])));

endmodule

bind tw_loader tw_loader_chk #(
  .FREQ_W(FREQ_W), .CTRL_W(CTRL_W), .BUS_W(BUS_W), .PHASE_W(PHASE_W),
  .PHASE_LSB(PHASE_LSB), .PD_BIT(PD_BIT)
) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .serial_mode (serial_mode),
  .wld_rise    (wld_rise),
  .upd_rise    (upd_rise),
  .data_in     (data_in),
  .stage_q     (stage_q),
  .cnt_q       (cnt_q),
  .freq_word   (freq_word),
  .phase_off   (phase_off),
  .pwr_down    (pwr_down)
);

// File: tb/tw_loader_test.sv
module tw_loader_test;

  logic        clk;
  logic        rst_n;
  logic        serial_mode;
  logic        wld_in;
  logic        upd_in;
  logic [7:0]  data_in;
  logic [31:0] freq_word;
  logic [4:0]  phase_off;
  logic        pwr_down;

  int checks = 0;
  int errors = 0;

  tw_loader uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .serial_mode (serial_mode),
    .wld_in      (wld_in),
    .upd_in      (upd_in),
    .data_in     (data_in),
    .freq_word   (freq_word),
    .phase_off   (phase_off),
    .pwr_down    (pwr_down)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: {serial, ctrl[7:0], freq[31:0]}
  localparam int NV = 5;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'hA4, 32'h1234_5678},
    {1'b1, 8'h7B, 32'h89AB_CDEF},
    {1'b0, 8'hFF, 32'hFFFF_FFFF},
    {1'b1, 8'h00, 32'h0000_0001},
    {1'b1, 8'hF8, 32'h8000_0000}
  };

  function automatic logic [37:0] expect_of(input logic [7:0] c, input logic [31:0] f);
    return {c[2], c[7:3], f};
  endfunction

  task automatic check(input string req, input logic [37:0] exp);
    logic [37:0] act;
    act = {pwr_down, phase_off, freq_word};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] b, input int hi);
    @(negedge clk);
    data_in = b;
    wld_in  = 1'b1;
    repeat (hi) @(negedge clk);
    wld_in  = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic update();
    @(negedge clk);
    upd_in = 1'b1;
    repeat (4) @(negedge clk);
    upd_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_par(input logic [7:0] c, input logic [31:0] f, input int hi0);
    serial_mode = 1'b0;
    strobe(c, hi0);
    strobe(f[31:24], 4);
    strobe(f[23:16], 4);
    strobe(f[15:8], 4);
    strobe(f[7:0], 4);
  endtask

  task automatic load_ser(input logic [7:0] c, input logic [31:0] f);
    logic [39:0] w;
    w = {c, f};
    serial_mode = 1'b1;
    for (int i = 0; i < 40; i++) strobe({w[i], 7'h55 ^ 7'(i)}, 4);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1; serial_mode = 1'b0; wld_in = 1'b0; upd_in = 1'b0; data_in = 8'h00;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 reset state", 38'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release", 38'h0);

    // table walk: R2 parallel order, R4 serial order, R3 field mapping
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][40]) load_ser(VEC[v][39:32], VEC[v][31:0]);
      else            load_par(VEC[v][39:32], VEC[v][31:0], 4);
      update();
      check(VEC[v][40] ? "R4 R3 serial vector" : "R2 R3 parallel vector",
            expect_of(VEC[v][39:32], VEC[v][31:0]));
    end

    // R6: loading without update leaves outputs
    load_par(8'h5C, 32'hCAFE_F00D, 4);
    check("R6 load without update", expect_of(8'hF8, 32'h8000_0000));
    update();
    check("R6 after update", expect_of(8'h5C, 32'hCAFE_F00D));

    // R5: extra parallel bytes dropped
    load_par(8'h3C, 32'h0102_0304, 4);
    strobe(8'hFF, 4);
    strobe(8'hEE, 4);
    update();
    check("R5 extra parallel bytes", expect_of(8'h3C, 32'h0102_0304));

    // R5: extra serial bits dropped
    load_ser(8'h94, 32'h7654_3210);
    strobe(8'h80, 4);
    strobe(8'h80, 4);
    strobe(8'h80, 4);
    update();
    check("R5 extra serial bits", expect_of(8'h94, 32'h7654_3210));

    // R7: partial word abandoned by update, next load starts at byte 0
    serial_mode = 1'b0;
    strobe(8'h11, 4);
    strobe(8'h22, 4);
    update();
    load_par(8'hD0, 32'hA5A5_0F0F, 4);
    update();
    check("R7 rewind after partial", expect_of(8'hD0, 32'hA5A5_0F0F));

    // R8: long strobe counts once
    load_par(8'h6C, 32'h0BAD_BEEF, 30);
    update();
    check("R8 long strobe single byte", expect_of(8'h6C, 32'h0BAD_BEEF));

    // R1: reset clears outputs but spares staging
    load_par(8'hE4, 32'h1357_9BDF, 4);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset clears outputs", 38'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 outputs stay clear", 38'h0);
    update();
    check("R1 staging kept through reset", expect_of(8'hE4, 32'h1357_9BDF));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule